// File: doc/BRIEF.md
# I2C Bus Condition Timer

This block supervises the two wires of an I2C bus. It recognises START and STOP conditions on the bus. A START or STOP is only accepted if the clock line has been high long enough beforehand, and a START must also be held long enough afterwards. Both intervals are counted in system clock cycles and set by a 5-bit value. A legal value is even and nonzero. Any other value raises an error flag, and the block then stays quiet.

The block also paces the bus controller when it creates a START or a STOP itself. After a one-cycle request, it sequences the open-drain pull-down enables of the clock and data lines through a setup phase and a hold phase. A single select bit chooses a short timing profile or a long one; the long profile is meant for system clocks of 4 MHz and above. The START and STOP sequences use different phase lengths. The controller's own drive is fed back through the bus wires, so a generated condition is also seen by the detector.

Top module: `i2c_cond_timer`

## Requirements
- R1: The setting is legal only when it is nonzero and even. `set_err` is high exactly while the setting captured at the previous clock edge is illegal. Reset loads the legal value 2.
- R2: A START is a falling edge of SDA while SCL is high. Counted after the two-flop synchronizers, SCL must have been high for at least `setting` cycles before the SDA edge; one cycle fewer gives no START.
- R3: After the SDA fall, SCL must stay high and SDA low for `setting/2` further cycles before `start_det` pulses. If SCL falls earlier, or SDA rises earlier, the START is dropped.
- R4: A STOP is a rising edge of SDA after SCL has been high for at least `setting` cycles. It pulses `stop_det`; one cycle fewer gives no STOP.
- R5: `start_det` and `stop_det` are one-cycle pulses and are never high together.
- R6: While `set_err` is high, no START or STOP is reported and no generation request is accepted.
- R7: A generated START follows this sequence after the request:
  - both enables are low for the START setup time: 10 cycles, or 20 with `long_gen`;
  - then `sda_oe` is high with `scl_oe` low for the START hold time: 10 cycles, or 20;
  - then both enables are high and `gen_busy` is low.
- R8: A generated STOP follows this sequence after the request:
  - `sda_oe` is high and `scl_oe` is low for the STOP setup time: 14 cycles, or 28;
  - then both enables are low while `gen_busy` stays high for 8 more cycles, or 16;
  - then the block is idle.
- R9: Generation requests that arrive while `gen_busy` is high are ignored. `gen_start` wins over `gen_stop` when both are requested together.
- R10: An SDA edge while SCL is low reports neither a START nor a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL bus level (asynchronous) |
| sda_in | input | 1 | Sampled SDA bus level (asynchronous) |
| cond_set | input | 5 | Detection window setting in clock cycles (even, nonzero) |
| long_gen | input | 1 | Selects the long generation timing profile |
| gen_start | input | 1 | One-cycle request to create a START |
| gen_stop | input | 1 | One-cycle request to create a STOP |
| start_det | output | 1 | One-cycle pulse on an accepted START |
| stop_det | output | 1 | One-cycle pulse on an accepted STOP |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| gen_busy | output | 1 | A generation sequence is in progress |
| set_err | output | 1 | The captured setting is illegal |

## Verification
The bench aims at off-by-one errors in the windows.
- Setup boundary: SCL is held high for exactly `setting` cycles and for one cycle fewer, for both edges and for two settings. A design that compared with `>` instead of `>=`, or whose counter started at the wrong cycle, would drop the legal START or STOP, or accept the short one.
- Hold boundary: SCL falls at the last acceptable cycle and one cycle earlier. A START reported on the short case would show a hold counter that starts too late or does not check SCL.
- Illegal settings: odd and zero settings are applied while legal-looking bus traffic and requests arrive. Any pulse or any generation activity then means the error gate is missing.
- Generation: each phase of both profiles is measured. A request is injected during the STOP bus-free time, which exposes swapped profiles, phases off by one, and requests that are accepted while busy.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [2:0] {
    G_IDLE,
    G_ST_SU,
    G_ST_HD,
    G_SP_SU,
    G_SP_HD
  } gen_st_e;

  typedef enum logic {
    D_IDLE,
    D_HOLD
  } det_st_e;

  // A setting is usable when it is nonzero and even.
  function automatic logic setting_ok(input int unsigned s);
    return (s != 0) && (s % 2 == 0);
  endfunction

  // Hold window that follows a START edge.
  function automatic int unsigned hold_of(input int unsigned s);
    return s / 2;
  endfunction

  // Length of one generation phase, picked by phase and profile.
  function automatic int unsigned phase_len(
    input gen_st_e     st,
    input logic        long_p,
    input int unsigned st_su_s, input int unsigned st_su_l,
    input int unsigned st_hd_s, input int unsigned st_hd_l,
    input int unsigned sp_su_s, input int unsigned sp_su_l,
    input int unsigned sp_hd_s, input int unsigned sp_hd_l
  );
    case (st)
      G_ST_SU: return long_p ? st_su_l : st_su_s;
      G_ST_HD: return long_p ? st_hd_l : st_hd_s;
      G_SP_SU: return long_p ? sp_su_l : sp_su_s;
      G_SP_HD: return long_p ? sp_hd_l : sp_hd_s;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
  parameter int W       = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_in[g];
        sync_q <= meta_q;
      end
    end
    assign d_out[g] = sync_q;
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SET_W = 5,
  localparam int CNT_W = SET_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic [SET_W-1:0] setting,
  input  logic             err,
  output logic             start_det,
  output logic             stop_det
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  det_st_e          st;
  logic             sda_d;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] setup_need;
  logic [CNT_W-1:0] hold_need;

  assign setup_need = CNT_W'(setting);
  assign hold_need  = CNT_W'(hold_of(int'(setting)));

  // Named internal events
  logic sda_fall, sda_rise, setup_met, start_edge, stop_edge, hold_ok, hold_done;
  assign sda_fall   = sda_d & ~sda_s;
  assign sda_rise   = ~sda_d & sda_s;
  assign setup_met  = (hi_cnt >= setup_need);
  assign start_edge = scl_s & sda_fall & setup_met & ~err;
  assign stop_edge  = scl_s & sda_rise & setup_met & ~err;
  assign hold_ok    = scl_s & ~sda_s;
  assign hold_done  = (st == D_HOLD) & hold_ok & (hcnt == hold_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= D_IDLE;
      sda_d     <= 1'b1;
      hi_cnt    <= '0;
      hcnt      <= '0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      sda_d     <= sda_s;
      start_det <= hold_done & ~err;
      stop_det  <= stop_edge;
      if (!scl_s)                hi_cnt <= '0;
      else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
      case (st)
        D_IDLE: if (start_edge) begin
          st   <= D_HOLD;
          hcnt <= CNT_W'(1);
        end
        D_HOLD: begin
          if (err || !hold_ok || hold_done) st <= D_IDLE;
          else                              hcnt <= hcnt + 1'b1;
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  // R5: pulses are one cycle wide and mutually exclusive
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !start_det);
  assert_stop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_det);
  assert_no_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
  // R6: an illegal setting silences the detector
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !start_det && !stop_det);
  // R3: a reported START had SCL high and SDA low just before
  assert_start_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> $past(scl_s) && !$past(sda_s));
  // R4/R10: a reported STOP had SDA high with SCL high
  assert_stop_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> $past(scl_s) && $past(sda_s));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int ST_SU_S = 10,
  parameter int ST_SU_L = 20,
  parameter int ST_HD_S = 10,
  parameter int ST_HD_L = 20,
  parameter int SP_SU_S = 14,
  parameter int SP_SU_L = 28,
  parameter int SP_HD_S = 8,
  parameter int SP_HD_L = 16,
  localparam int MAX_A = (ST_SU_L > ST_HD_L) ? ST_SU_L : ST_HD_L,
  localparam int MAX_B = (SP_SU_L > SP_HD_L) ? SP_SU_L : SP_HD_L,
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int GW    = $clog2(MAX_L + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_sel,
  input  logic gen_start,
  input  logic gen_stop,
  input  logic err,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy
);

  gen_st_e         st;
  logic            long_q;
  logic [GW-1:0]   gcnt;
  logic [GW-1:0]   cur_len;

  assign cur_len = GW'(phase_len(st, long_q, ST_SU_S, ST_SU_L, ST_HD_S, ST_HD_L,
                                 SP_SU_S, SP_SU_L, SP_HD_S, SP_HD_L));

  logic take_start, take_stop, phase_end;
  assign take_start = (st == G_IDLE) & ~err & gen_start;
  assign take_stop  = (st == G_IDLE) & ~err & ~gen_start & gen_stop;
  assign phase_end  = (st != G_IDLE) & (gcnt == cur_len - 1'b1);
  assign busy       = (st != G_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= G_IDLE;
      long_q <= 1'b0;
      gcnt   <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (take_start) begin
      st     <= G_ST_SU;
      long_q <= long_sel;
      gcnt   <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (take_stop) begin
      st     <= G_SP_SU;
      long_q <= long_sel;
      gcnt   <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b1;
    end else if (phase_end) begin
      gcnt <= '0;
      case (st)
        G_ST_SU: begin st <= G_ST_HD; sda_oe <= 1'b1; end
        G_ST_HD: begin st <= G_IDLE;  scl_oe <= 1'b1; end
        G_SP_SU: begin st <= G_SP_HD; sda_oe <= 1'b0; end
        default: st <= G_IDLE;
      endcase
    end else if (st != G_IDLE) begin
      gcnt <= gcnt + 1'b1;
    end
  end

  // R6: no sequence begins under an illegal setting
  assert_no_start_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(err));
  // R7: SCL is only pulled low while SDA is already held low
  assert_scl_after_sda_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> sda_oe);
  // R7/R8: when idle, both lines are either driven or released together
  assert_idle_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_oe == sda_oe));
  // R9: a running sequence does not restart into its first phase
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy && $past(sda_oe) && !$past(scl_oe) |-> !(scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer
  import i2c_cond_pkg::*;
#(
  parameter int SET_W   = 5,
  parameter int RST_SET = 2,
  parameter int ST_SU_S = 10,
  parameter int ST_SU_L = 20,
  parameter int ST_HD_S = 10,
  parameter int ST_HD_L = 20,
  parameter int SP_SU_S = 14,
  parameter int SP_SU_L = 28,
  parameter int SP_HD_S = 8,
  parameter int SP_HD_L = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [SET_W-1:0] cond_set,
  input  logic             long_gen,
  input  logic             gen_start,
  input  logic             gen_stop,
  output logic             start_det,
  output logic             stop_det,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             gen_busy,
  output logic             set_err
);

  logic [SET_W-1:0] set_q;
  logic [1:0]       line_s;
  logic             scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= SET_W'(RST_SET);
    else        set_q <= cond_set;
  end

  assign set_err = ~setting_ok(int'(set_q));

  i2c_cond_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_cond_detect #(.SET_W(SET_W)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .setting   (set_q),
    .err       (set_err),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_cond_gen #(
    .ST_SU_S(ST_SU_S), .ST_SU_L(ST_SU_L), .ST_HD_S(ST_HD_S), .ST_HD_L(ST_HD_L),
    .SP_SU_S(SP_SU_S), .SP_SU_L(SP_SU_L), .SP_HD_S(SP_HD_S), .SP_HD_L(SP_HD_L)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_sel  (long_gen),
    .gen_start (gen_start),
    .gen_stop  (gen_stop),
    .err       (set_err),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (gen_busy)
  );

  // R1: the error flag follows the setting captured one edge earlier
  assert_err_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cond_set) == 0 |-> set_err);
  assert_odd_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cond_set[0]) |-> set_err);

endmodule

// File: tb/i2c_cond_timer_tb.sv
module i2c_cond_timer_tb;

  localparam int K_START = 1;
  localparam int K_STOP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_scl = 1'b1, tb_sda = 1'b1;
  logic [4:0] cond_set = 5'd8;
  logic       long_gen = 1'b0, gen_start = 1'b0, gen_stop = 1'b0;
  logic       start_det, stop_det, scl_oe, sda_oe, gen_busy, set_err;
  logic       scl_in, sda_in;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct { int kind; string req; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  assign scl_in = tb_scl & ~scl_oe;
  assign sda_in = tb_sda & ~sda_oe;

  i2c_cond_timer u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .cond_set(cond_set), .long_gen(long_gen), .gen_start(gen_start), .gen_stop(gen_stop),
    .start_det(start_det), .stop_det(stop_det), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .gen_busy(gen_busy), .set_err(set_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_evt(input int kind, input string req);
    exp_t e;
    e.kind = kind; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_n && (start_det || stop_det)) begin
      int got;
      got = start_det ? K_START : K_STOP;
      if (start_det && stop_det) check(0, "R5 both", 3, 1);
      else if (exp_q.size() == 0) check(0, "R2/R3/R4/R6/R10 unexpected pulse", got, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(got == e.kind, e.req, got, e.kind);
      end
    end
  end

  task automatic drain(input string req);
    cyc(12);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // SCL rises, N cycles later SDA falls, L cycles later SCL falls
  task automatic try_start(input int n, input int l, input bit exp, input string req);
    tb_scl = 0; cyc(3);
    tb_sda = 1; cyc(3);       // R10: SDA rise with SCL low
    tb_scl = 1; cyc(n);
    tb_sda = 0;
    if (exp) expect_evt(K_START, req);
    cyc(l);
    tb_scl = 0; cyc(3);
    drain(req);
  endtask

  task automatic try_stop(input int n, input bit exp, input string req);
    tb_scl = 0; cyc(3);
    tb_sda = 0; cyc(3);       // R10: SDA fall with SCL low
    tb_scl = 1; cyc(n);
    tb_sda = 1;
    if (exp) expect_evt(K_STOP, req);
    drain(req);
  endtask

  task automatic pulse_start();
    gen_start = 1; @(negedge clk); gen_start = 0;
  endtask

  task automatic pulse_stop();
    gen_stop = 1; @(negedge clk); gen_stop = 0;
  endtask

  task automatic gen_start_seq(input bit lng);
    int n;
    int su;
    int hd;
    su = lng ? 20 : 10;
    hd = lng ? 20 : 10;
    long_gen = lng;
    expect_evt(K_START, "R7 generated start seen");
    pulse_start();
    n = 0;
    while (gen_busy && !sda_oe && !scl_oe && n < 200) begin n++; @(negedge clk); end
    check(n == su, "R7 start setup", n, su);
    n = 0;
    while (gen_busy && sda_oe && !scl_oe && n < 200) begin n++; @(negedge clk); end
    check(n == hd, "R7 start hold", n, hd);
    check(scl_oe && sda_oe && !gen_busy, "R7 start end", {gen_busy, scl_oe, sda_oe}, 3);
    cyc(4);
  endtask

  task automatic gen_stop_seq(input bit lng);
    int n;
    int su;
    int hd;
    su = lng ? 28 : 14;
    hd = lng ? 16 : 8;
    long_gen = lng;
    expect_evt(K_STOP, "R8 generated stop seen");
    pulse_stop();
    n = 0;
    while (gen_busy && sda_oe && !scl_oe && n < 200) begin n++; @(negedge clk); end
    check(n == su, "R8 stop setup", n, su);
    n = 0;
    gen_start = 1;            // R9: request during bus-free time is ignored
    while (gen_busy && !sda_oe && !scl_oe && n < 200) begin
      n++; @(negedge clk); gen_start = 0;
    end
    check(n == hd, "R8 stop bus free", n, hd);
    cyc(5);
    check(!gen_busy && !sda_oe && !scl_oe, "R9 busy request ignored",
          {gen_busy, scl_oe, sda_oe}, 0);
    drain("R8 stop drain");
    cyc(10);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check({start_det, stop_det, scl_oe, sda_oe, gen_busy, set_err} == 6'b0,
          "reset state", {start_det, stop_det, scl_oe, sda_oe, gen_busy, set_err}, 0);
    cyc(2);
    check(set_err == 0, "R1 legal 8", set_err, 0);

    // setting 8: setup 8, hold 4
    try_start(8, 12, 1, "R2 start at setup");
    try_start(7, 12, 0, "R2 start short setup");
    try_start(8, 5, 1, "R3 hold boundary");
    try_start(8, 4, 0, "R3 hold too short");
    try_stop(8, 1, "R4 stop at setup");
    try_stop(7, 0, "R4 stop short setup");
    try_stop(25, 1, "R10 stop after low-SCL edges");

    // setting 4: setup 4, hold 2
    cond_set = 5'd4; cyc(2);
    try_start(4, 3, 1, "R2 start set4");
    try_start(3, 3, 0, "R2 start set4 short");
    try_stop(3, 0, "R4 stop set4 short");
    try_stop(4, 1, "R4 stop set4");

    // illegal settings
    cond_set = 5'd7; cyc(2);
    check(set_err == 1, "R1 odd setting", set_err, 1);
    try_start(20, 12, 0, "R6 no start while error");
    try_stop(20, 0, "R6 no stop while error");
    pulse_start(); cyc(3);
    check(!gen_busy && !sda_oe && !scl_oe, "R6 no generation while error",
          {gen_busy, scl_oe, sda_oe}, 0);
    cond_set = 5'd0; cyc(2);
    check(set_err == 1, "R1 zero setting", set_err, 1);
    cond_set = 5'd8; cyc(2);
    check(set_err == 0, "R1 legal again", set_err, 0);
    cyc(20);

    // generation, both profiles
    gen_start_seq(0);
    gen_stop_seq(0);
    gen_start_seq(1);
    gen_stop_seq(1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule